// File: doc/BRIEF.md
# FP8 Pack and Extract Unit

This unit converts between 32-bit IEEE single-precision floats and a 32-bit word that carries four 8-bit floating-point elements. Three operations are offered. An extract widens one chosen element to fp32. A stochastic pack rounds a single fp32 operand into one element, adding a caller-supplied random term during rounding. A pair pack rounds two fp32 operands with round-to-nearest-even into either the lower or the upper half of the word. Every element position that an operation does not write is taken from a supplied base word.

Two 8-bit formats are handled, both without infinities and without negative zero. A format bit selects between them. With a 0 it is the 4-exponent/3-mantissa format (bias 8, largest finite 240). With a 1 it is the 5-exponent/2-mantissa format (bias 16, largest finite 57344). A request is accepted with a valid/ready handshake. Its result is registered and offered one cycle later on a valid/ready output.

Top module: `fp8_pack_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A request is taken when `in_valid` and `in_ready` are both 1, and its result shows on `out_data` with `out_valid` at the next clock. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds. `in_ready` is 1 whenever the output register is empty or is being drained in that cycle, and results leave in request order.
- R3: With `in_op` = 0 (extract), `out_data` is the exact fp32 value of element `in_sel` of `in_base`. Element k occupies bits [8k+7:8k]. An element byte holds a sign in bit 7, then the exponent, then the mantissa.
- R4: Extracting the byte 0x80 gives the quiet NaN 0x7FC00000. Extracting 0x00 gives +0.0 (0x00000000).
- R5: With `in_op` = 1 (stochastic pack), `in_src_a` is rounded into element `in_sel`. The bits of `in_rand` below the rounding point are added to the discarded fraction, and a carry out of that fraction rounds the magnitude up. Higher bits of `in_rand` are ignored. The other three elements are copied from `in_base`.
- R6: With `in_op` = 2 (pair pack), `in_sel[0]` picks the half: 0 gives elements 0 and 1, 1 gives elements 2 and 3. `in_src_a` goes to the lower element of that half and `in_src_b` to the upper one. The other half is copied from `in_base`, and `in_sel[1]` is ignored.
- R7: Pair pack rounds to nearest, and an exact tie goes to the even mantissa.
- R8: A magnitude that exceeds the largest finite value after rounding saturates to 0x7F with the input's sign. This includes infinities and a rounding carry out of the top exponent.
- R9: An fp32 NaN packs to 0x80. A result whose magnitude rounds to zero packs to 0x00 whatever its sign, so 0x80 never comes from a number.
- R10: With `in_op` = 3, `out_data` equals `in_base`.
- R11: Subnormal elements (exponent field 0) are widened exactly. Small fp32 inputs pack into subnormal codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 2 | 0 extract, 1 stochastic pack, 2 pair pack, 3 pass base |
| in_fmt | input | 1 | 0: 4-bit exponent format, 1: 5-bit exponent format |
| in_sel | input | 2 | Element index; bit 0 is the half index for pair pack |
| in_src_a | input | 32 | First fp32 operand |
| in_src_b | input | 32 | Second fp32 operand (pair pack) |
| in_rand | input | 32 | Random term for stochastic rounding |
| in_base | input | 32 | Packed word to extract from or merge into |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | fp32 value or packed word |

## Verification
The output register can hand a result to the consumer and take in the next request on the same clock edge. A stuck or late `in_ready` shows up exactly there. The bench first streams requests with the consumer always ready, so every cycle both drains and refills. It then switches to a repeating pattern in which the consumer refuses one cycle in three, so requests wait on `in_ready` and results wait on `out_ready`. A scoreboard queue judges each result in order against hand-derived values, and the bench also checks that a held result does not change while it waits.

// File: rtl/fp8_pkg.sv
package fp8_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ELEM_W  = 8;
  localparam int unsigned ELEMS   = WORD_W / ELEM_W;
  localparam int unsigned SEL_W   = $clog2(ELEMS);
  localparam logic [31:0] F32_QNAN = 32'h7FC0_0000;
  localparam logic [7:0]  FP8_NAN  = 8'h80;

  typedef enum logic [1:0] {
    OP_EXTRACT = 2'd0,
    OP_STOCH   = 2'd1,
    OP_PAIR    = 2'd2,
    OP_PASS    = 2'd3
  } op_e;

  // mantissa width and exponent bias per element format
  function automatic int mant_bits(input logic fmt);
    return fmt ? 2 : 3;
  endfunction

  function automatic int exp_bias(input logic fmt);
    return fmt ? 16 : 8;
  endfunction

  // exact widening of one element byte to fp32
  function automatic logic [31:0] widen_elem(input logic [7:0] b, input logic fmt);
    int mw, bias, e, m, p, ex32, mant;
    mw   = mant_bits(fmt);
    bias = exp_bias(fmt);
    e    = int'(b[6:0]) >> mw;
    m    = int'(b[6:0]) & ((1 << mw) - 1);
    if (b == FP8_NAN) return F32_QNAN;
    if (b[6:0] == 7'd0) return 32'h0;
    if (e != 0) begin
      ex32 = e - bias + 127;
      mant = m << (23 - mw);
    end else begin
      p = 0;
      for (int i = 0; i < 3; i++) if (m[i]) p = i;
      ex32 = p + 1 - bias - mw + 127;
      mant = (m & ~(1 << p)) << (23 - p);
    end
    return {b[7], 8'(ex32), 23'(mant)};
  endfunction

  // rounding narrow of fp32 to one element byte
  function automatic logic [7:0] narrow_elem(input logic [31:0] x, input logic fmt,
                                             input logic stoch, input logic [31:0] rnd);
    int mw, bias, eeff, te, sh, code;
    logic [7:0]  e;
    logic [31:0] sig, mask, rem, q, half;
    logic [32:0] sum;
    logic        up;
    mw   = mant_bits(fmt);
    bias = exp_bias(fmt);
    e    = x[30:23];
    if (e == 8'hFF && x[22:0] != 23'd0) return FP8_NAN;
    if (e == 8'hFF) return {x[31], 7'h7F};
    eeff = (e == 8'd0) ? 1 : int'(e);
    te   = eeff - 127 + bias;
    sig  = {8'd0, (e != 8'd0), x[22:0]};
    sh   = 23 - mw + ((te < 1) ? (1 - te) : 0);
    if (sh > 31) sh = 31;
    mask = (32'h1 << sh) - 32'h1;
    rem  = sig & mask;
    q    = sig >> sh;
    half = 32'h1 << (sh - 1);
    if (stoch) begin
      sum = {1'b0, rem} + {1'b0, rnd & mask};
      up  = (sum >> sh) != 33'd0;
    end else begin
      up  = (rem > half) || ((rem == half) && q[0]);
    end
    code = ((te >= 1) ? ((te - 1) << mw) : 0) + int'(q) + (up ? 1 : 0);
    if (code > 127) code = 127;
    if (code == 0) return 8'h00;
    return {x[31], code[6:0]};
  endfunction
endpackage

// File: rtl/fp8_elem_widen.sv
module fp8_elem_widen
  import fp8_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  input  logic              fmt,
  output logic [ELEM_W-1:0] picked,
  output logic [31:0]       value
);
  logic [ELEM_W-1:0] elems [ELEMS];

  for (genvar k = 0; k < ELEMS; k++) begin : g_split
    assign elems[k] = word[k*ELEM_W +: ELEM_W];
  end

  assign picked = elems[sel];
  assign value  = widen_elem(picked, fmt);
endmodule

// File: rtl/fp8_elem_narrow.sv
module fp8_elem_narrow
  import fp8_pkg::*;
(
  input  logic [31:0]       src,
  input  logic              fmt,
  input  logic              stoch,
  input  logic [31:0]       rnd,
  output logic [ELEM_W-1:0] code,
  output logic              src_nan
);
  assign src_nan = (src[30:23] == 8'hFF) && (src[22:0] != 23'd0);
  assign code    = narrow_elem(src, fmt, stoch, rnd);
endmodule

// File: rtl/fp8_slot_merge.sv
module fp8_slot_merge
  import fp8_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  op_e               op,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ELEM_W-1:0] code_a,
  input  logic [ELEM_W-1:0] code_b,
  output logic [ELEMS-1:0]  wr_mask,
  output logic [WORD_W-1:0] merged
);
  localparam int unsigned HALF = ELEMS / 2;

  always_comb begin
    wr_mask = '0;
    case (op)
      OP_STOCH: wr_mask[sel] = 1'b1;
      OP_PAIR:  wr_mask = sel[0] ? {{HALF{1'b1}}, {HALF{1'b0}}}
                                 : {{HALF{1'b0}}, {HALF{1'b1}}};
      default:  wr_mask = '0;
    endcase
  end

  for (genvar k = 0; k < ELEMS; k++) begin : g_slot
    logic [ELEM_W-1:0] fresh;
    assign fresh = (op == OP_PAIR && (k % 2) == 1) ? code_b : code_a;
    assign merged[k*ELEM_W +: ELEM_W] = wr_mask[k] ? fresh : base[k*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/fp8_pack_unit.sv
module fp8_pack_unit
  import fp8_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_op,
  input  logic        in_fmt,
  input  logic [1:0]  in_sel,
  input  logic [31:0] in_src_a,
  input  logic [31:0] in_src_b,
  input  logic [31:0] in_rand,
  input  logic [31:0] in_base,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data
);
  op_e               op;
  logic              accept;
  logic [ELEM_W-1:0] ext_byte;
  logic [31:0]       ext_value;
  logic [ELEM_W-1:0] codes [2];
  logic [1:0]        lane_nan;
  logic [ELEMS-1:0]  wr_mask;
  logic [WORD_W-1:0] merged;
  logic [31:0]       result;

  assign op       = op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fp8_elem_widen u_widen (
    .word(in_base), .sel(in_sel), .fmt(in_fmt), .picked(ext_byte), .value(ext_value)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    fp8_elem_narrow u_narrow (
      .src    ((l == 0) ? in_src_a : in_src_b),
      .fmt    (in_fmt),
      .stoch  ((l == 0) && (op == OP_STOCH)),
      .rnd    (in_rand),
      .code   (codes[l]),
      .src_nan(lane_nan[l])
    );
  end

  fp8_slot_merge u_merge (
    .base(in_base), .op(op), .sel(in_sel), .code_a(codes[0]), .code_b(codes[1]),
    .wr_mask(wr_mask), .merged(merged)
  );

  assign result = (op == OP_EXTRACT) ? ext_value : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_nan_extract_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_EXTRACT && ext_byte == FP8_NAN |=> out_data == F32_QNAN);

  assert_stoch_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_STOCH |=>
      ((out_data ^ $past(in_base)) & ~(32'hFF << (8 * $past(in_sel)))) == 32'h0);

  assert_pair_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_PAIR |=>
      ($past(in_sel[0]) ? out_data[15:0] == $past(in_base[15:0])
                        : out_data[31:16] == $past(in_base[31:16])));

  assert_nan_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (codes[0] == FP8_NAN) |-> lane_nan[0]);

  assert_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_PASS |=> out_data == $past(in_base));
endmodule

// File: tb/test_fp8_pack_unit.sv
module test_fp8_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic        in_fmt = 1'b0;
  logic [1:0]  in_sel = '0;
  logic [31:0] in_src_a = '0, in_src_b = '0, in_rand = '0, in_base = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  fp8_pack_unit i_fp8_pack_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fmt(in_fmt), .in_sel(in_sel), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_rand(in_rand), .in_base(in_base),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // consumer readiness: always ready, or refuse one cycle in three
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? ((cnt % 3) != 0) : 1'b1;
      cnt++;
    end
  end

  // monitor: pops the scoreboard on every transfer, checks held data
  initial begin
    bit          held = 1'b0;
    logic [31:0] held_data = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (held && out_valid)
          check(out_data == held_data, "R2 held result stable", out_data, held_data);
        held = out_valid && !out_ready;
        held_data = out_data;
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R2 unexpected result", out_data, 32'h0);
          end else begin
            item_t it;
            it = sb.pop_front();
            check(out_data == it.data, it.tag, out_data, it.data);
          end
        end
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic fmt, input logic [1:0] sel,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] rnd,
                      input logic [31:0] base, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    in_op = op; in_fmt = fmt; in_sel = sel; in_src_a = a; in_src_b = b;
    in_rand = rnd; in_base = base; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.data = exp;
    it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
  endtask

  task automatic run_all();
    // extract (op 0)
    send(2'd0, 1'b0, 2'd2, 0, 0, 0, 32'h1140_2233, 32'h3F80_0000, "R3 e4 1.0 slot2");
    send(2'd0, 1'b0, 2'd0, 0, 0, 0, 32'h0000_00C5, 32'hBFD0_0000, "R3 e4 -1.625 slot0");
    send(2'd0, 1'b1, 2'd3, 0, 0, 0, 32'h7B00_0000, 32'h46E0_0000, "R3 e5 28672 slot3");
    send(2'd0, 1'b0, 2'd1, 0, 0, 0, 32'h0000_0300, 32'h3B40_0000, "R11 e4 subnormal widen");
    send(2'd0, 1'b1, 2'd0, 0, 0, 0, 32'h0000_0080, 32'h7FC0_0000, "R4 0x80 widens to NaN");
    send(2'd0, 1'b0, 2'd3, 0, 0, 0, 32'h00FF_FFFF, 32'h0000_0000, "R4 0x00 widens to +0");
    send(2'd0, 1'b1, 2'd2, 0, 0, 0, 32'h0001_0000, 32'h3700_0000, "R11 e5 subnormal widen");
    // stochastic pack (op 1)
    send(2'd1, 1'b0, 2'd1, 32'h3F80_0000, 0, 32'h0, 32'hAABB_CCDD, 32'hAABB_40DD, "R5 exact 1.0 slot1");
    send(2'd1, 1'b0, 2'd3, 32'h3F88_0000, 0, 32'hFFF8_0000, 32'h1234_5678, 32'h4134_5678, "R5 random carry rounds up");
    send(2'd1, 1'b0, 2'd0, 32'h3F88_0000, 0, 32'hFFF7_FFFF, 32'h1234_5678, 32'h1234_5640, "R5 random no carry");
    stall_mode = 1'b1;
    send(2'd1, 1'b0, 2'd2, 32'h447A_0000, 0, 32'h0, 32'h0, 32'h007F_0000, "R8 e4 1000 saturates");
    send(2'd1, 1'b1, 2'd0, 32'hFF80_0000, 0, 32'h0, 32'h0, 32'h0000_00FF, "R8 -inf saturates");
    send(2'd1, 1'b1, 2'd1, 32'h7FC0_0000, 0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_80FF, "R9 NaN packs to 0x80");
    send(2'd1, 1'b0, 2'd0, 32'hB580_0000, 0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FF00, "R9 negative tiny to +0");
    // pair pack (op 2)
    send(2'd2, 1'b0, 2'd0, 32'h3F88_0000, 32'h3F98_0000, 32'h0, 32'hDEAD_BEEF, 32'hDEAD_4240, "R7 ties to even low half");
    send(2'd2, 1'b1, 2'd3, 32'hC000_0000, 32'h37C0_0000, 32'h0, 32'h0102_BEEF, 32'h03C4_BEEF, "R6 high half sel1 ignored R11");
    send(2'd2, 1'b1, 2'd0, 32'h4770_0000, 32'h0, 32'h0, 32'hAAAA_AAAA, 32'hAAAA_007F, "R8 rounding carry saturates");
    // pass (op 3)
    send(2'd3, 1'b0, 2'd2, 32'h3F80_0000, 0, 32'h0, 32'h5A5A_1234, 32'h5A5A_1234, "R10 pass base");
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'h1);
    run_all();
    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R2 all results delivered in order", sb.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule